// File: doc/BRIEF.md
# Two-Line Interrupt Aggregator

This block gathers a vector of event pulses into a sticky flag register and turns the pending flags into two interrupt outputs. Any source pulse sets its flag, whatever the enables say. Software sees the flags through a small register bus. It clears a flag by writing a one to that bit, which means it can write back the value it just read.

Each flag has a per-bit enable and a per-bit line select. An enabled flag is routed to interrupt line 0 or line 1 by its select bit. Each line has its own master enable bit, so software can mask one line and keep the other one running.

The register bus is run by a small state machine with three named states. BST_IDLE is the only state that accepts a request (`bus_ready_o` high). From BST_IDLE, an accepted read takes the transition to BST_RDATA, where `bus_rvalid_o` is high for one cycle and the read data is shown. An accepted write takes the transition to BST_WDONE, which is a single quiet cycle. Both BST_RDATA and BST_WDONE go back to BST_IDLE on the next edge, whatever is on the inputs. If no request is present, BST_IDLE stays in BST_IDLE.

Register addresses (2-bit word index):
- 0: flags, write 1 to clear.
- 1: enable mask.
- 2: line select.
- 3: line enable.

Top module: `irq_two_line_agg`

## Requirements
- R1: After reset, the following are all zero: the flags, enable, select and line-enable registers, both interrupt lines and `bus_rvalid_o`. `bus_ready_o` is high after reset.
- R2: A source bit that is high at a clock edge sets its flag at that edge. The flag stays set after the source drops. This happens whatever the enable, select and line-enable registers hold.
- R3: An accepted write to address 0 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: If a source bit is high at the same edge that a write to address 0 clears that bit, the flag stays set.
- R5: Line 0 is the OR, over bits whose select bit (address 2) is 0, of flag AND enable bit (address 1). Line 1 is the same OR over bits whose select bit is 1. The lines follow the registers in the cycle after any update.
- R6: Bit 0 of the line-enable register (address 3) gates line 0, and bit 1 gates line 1. Writing 3 opens both lines and writing 0 masks both.
- R7: Reads return the following:
  - addresses 1 and 2: all 32 bits as written;
  - address 3: its two bits, zero-extended;
  - address 0: the flags as held just before the accepting edge.
- R8: A request is accepted only in BST_IDLE. An accepted read gives `bus_rvalid_o` high for exactly the next cycle, with the data on `bus_rdata_o`. Any request seen in BST_RDATA or BST_WDONE has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Source event bits, sampled every edge |
| bus_req_i | input | 1 | Access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_ready_o | output | 1 | High in BST_IDLE; a request is accepted only then |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 2 | Interrupt lines 0 and 1 |

## Verification
The assertions take two things for granted:
- a request is only meaningful while `bus_ready_o` is high;
- the source bits are synchronous to the clock.

The clear property assumes that no source bit fires in the cycle it checks. The collision case is left to directed stimulus.

The bench issues one access at a time. It waits out the response state before presenting the next request, except in one directed case that holds the request high into BST_WDONE to show that it is ignored. Source bits are random and sparse, and are applied at the negative edge so that they are held across the sampling edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int REG_AW    = 2;
    localparam int NUM_LINES = 2;

    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_RDATA = 2'd1,
        BST_WDONE = 2'd2
    } bus_state_t;

    typedef enum logic [REG_AW-1:0] {
        RA_FLAG    = 2'd0,
        RA_ENABLE  = 2'd1,
        RA_SELECT  = 2'd2,
        RA_LINE_EN = 2'd3
    } reg_addr_t;
endpackage

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    output logic              ready_o,
    output logic              rvalid_o,
    output logic              rd_stb_o,
    output logic              wr_flag_o,
    output logic              wr_en_o,
    output logic              wr_sel_o,
    output logic              wr_le_o
);
    bus_state_t state_q, state_d;
    reg_addr_t  ra;

    assign ra = reg_addr_t'(addr_i);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BST_IDLE:  if (req_i) state_d = we_i ? BST_WDONE : BST_RDATA;
            BST_RDATA: state_d = BST_IDLE;
            BST_WDONE: state_d = BST_IDLE;
            default:   state_d = BST_IDLE;
        endcase
    end

    // Outputs and access strobes
    always_comb begin
        ready_o   = 1'b0;
        rvalid_o  = 1'b0;
        rd_stb_o  = 1'b0;
        wr_flag_o = 1'b0;
        wr_en_o   = 1'b0;
        wr_sel_o  = 1'b0;
        wr_le_o   = 1'b0;
        unique case (state_q)
            BST_IDLE: begin
                ready_o  = 1'b1;
                rd_stb_o = req_i && !we_i;
                if (req_i && we_i) begin
                    unique case (ra)
                        RA_FLAG:    wr_flag_o = 1'b1;
                        RA_ENABLE:  wr_en_o   = 1'b1;
                        RA_SELECT:  wr_sel_o  = 1'b1;
                        RA_LINE_EN: wr_le_o   = 1'b1;
                        default:    ;
                    endcase
                end
            end
            BST_RDATA: rvalid_o = 1'b1;
            BST_WDONE: ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_stb_i,
    input  logic [N_SRC-1:0] clr_mask_i,
    output logic [N_SRC-1:0] flag_o
);
    for (genvar b = 0; b < N_SRC; b++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                          f_q <= 1'b0;
            else if (evt_i[b])                   f_q <= 1'b1;  // set beats clear
            else if (clr_stb_i && clr_mask_i[b]) f_q <= 1'b0;
        end
        assign flag_o[b] = f_q;
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 wr_sel_i,
    input  logic                 wr_le_i,
    input  logic [N_SRC-1:0]     wdata_i,
    output logic [N_SRC-1:0]     en_o,
    output logic [N_SRC-1:0]     sel_o,
    output logic [NUM_LINES-1:0] le_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= '0;
            sel_o <= '0;
            le_o  <= '0;
        end else begin
            if (wr_en_i)  en_o  <= wdata_i;
            if (wr_sel_i) sel_o <= wdata_i;
            if (wr_le_i)  le_o  <= wdata_i[NUM_LINES-1:0];
        end
    end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0]     flag_i,
    input  logic [N_SRC-1:0]     en_i,
    input  logic [N_SRC-1:0]     sel_i,
    input  logic [NUM_LINES-1:0] le_i,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [N_SRC-1:0] live;
    assign live = flag_i & en_i;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [N_SRC-1:0] routed;
        if (l == 0) begin : g_lo
            assign routed = live & ~sel_i;
        end else begin : g_hi
            assign routed = live & sel_i;
        end
        assign irq_o[l] = (|routed) & le_i[l];
    end
endmodule

// File: rtl/irq_two_line_agg.sv
module irq_two_line_agg
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     evt_i,
    input  logic                 bus_req_i,
    input  logic                 bus_we_i,
    input  logic [REG_AW-1:0]    bus_addr_i,
    input  logic [N_SRC-1:0]     bus_wdata_i,
    output logic                 bus_ready_o,
    output logic                 bus_rvalid_o,
    output logic [N_SRC-1:0]     bus_rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);
    localparam int PAD_W = N_SRC - NUM_LINES;

    logic rd_stb, wr_flag, wr_en, wr_sel, wr_le;
    logic [N_SRC-1:0]     flag_q, en_q, sel_q;
    logic [NUM_LINES-1:0] le_q;
    logic [N_SRC-1:0]     rdata_q;

    irq_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bus_req_i),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .ready_o   (bus_ready_o),
        .rvalid_o  (bus_rvalid_o),
        .rd_stb_o  (rd_stb),
        .wr_flag_o (wr_flag),
        .wr_en_o   (wr_en),
        .wr_sel_o  (wr_sel),
        .wr_le_o   (wr_le)
    );

    irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_stb_i  (wr_flag),
        .clr_mask_i (bus_wdata_i),
        .flag_o     (flag_q)
    );

    irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_sel_i (wr_sel),
        .wr_le_i  (wr_le),
        .wdata_i  (bus_wdata_i),
        .en_o     (en_q),
        .sel_o    (sel_q),
        .le_o     (le_q)
    );

    irq_line_router #(.N_SRC(N_SRC)) u_route (
        .flag_i (flag_q),
        .en_i   (en_q),
        .sel_i  (sel_q),
        .le_i   (le_q),
        .irq_o  (irq_o)
    );

    // Read data captured at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_stb) begin
            unique case (reg_addr_t'(bus_addr_i))
                RA_FLAG:    rdata_q <= flag_q;
                RA_ENABLE:  rdata_q <= en_q;
                RA_SELECT:  rdata_q <= sel_q;
                RA_LINE_EN: rdata_q <= {{PAD_W{1'b0}}, le_q};
                default:    rdata_q <= '0;
            endcase
        end
    end
    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_SRC-1:0]     evt,
    input logic                 req,
    input logic                 we,
    input logic [REG_AW-1:0]    addr,
    input logic [N_SRC-1:0]     wdata,
    input logic                 ready,
    input logic                 rvalid,
    input logic [N_SRC-1:0]     flags,
    input logic [N_SRC-1:0]     en,
    input logic [NUM_LINES-1:0] le,
    input logic [NUM_LINES-1:0] irq
);
    // R2: a source pulse always leaves its flag set
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags & $past(evt)) == $past(evt)));

    // R3: a clear write with no events drops exactly the written ones
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && we && addr == 2'd0 && evt == '0)
        |=> (flags == ($past(flags) & ~$past(wdata))));

    // R6: a masked line stays low
    assert_line0_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !le[0] |-> !irq[0]);
    assert_line1_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !le[1] |-> !irq[1]);

    // R8: accepted read gives one rvalid cycle
    assert_rvalid_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !we) |=> rvalid);
    assert_rvalid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R8: a request while busy leaves the enable register alone
    assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ready) |=> $stable(en));
endmodule

bind irq_two_line_agg irq_agg_checker #(.N_SRC(N_SRC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_i),
    .req    (bus_req_i),
    .we     (bus_we_i),
    .addr   (bus_addr_i),
    .wdata  (bus_wdata_i),
    .ready  (bus_ready_o),
    .rvalid (bus_rvalid_o),
    .flags  (flag_q),
    .en     (en_q),
    .le     (le_q),
    .irq    (irq_o)
);

// File: tb/tb_irq_two_line_agg.sv
`timescale 1ns/1ps
module tb_irq_two_line_agg;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_i = '0;
    logic          bus_req_i = 1'b0;
    logic          bus_we_i = 1'b0;
    logic [1:0]    bus_addr_i = '0;
    logic [N-1:0]  bus_wdata_i = '0;
    logic          bus_ready_o, bus_rvalid_o;
    logic [N-1:0]  bus_rdata_o;
    logic [1:0]    irq_o;

    always #2.5 clk = ~clk;

    irq_two_line_agg #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_ready_o(bus_ready_o),
        .bus_rvalid_o(bus_rvalid_o), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [N-1:0] m_flag = '0, m_en = '0, m_sel = '0;
    logic [1:0]   m_le = '0;

    function automatic logic [1:0] exp_irq(logic [N-1:0] f, logic [N-1:0] e,
                                           logic [N-1:0] s, logic [1:0] le);
        logic [1:0] r;
        r[0] = (|(f & e & ~s)) & le[0];
        r[1] = (|(f & e & s)) & le[1];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return m_flag;
            2'd1:    return m_en;
            2'd2:    return m_sel;
            default: return {30'b0, m_le};
        endcase
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access (or an idle cycle with events), then wait out the response.
    task automatic do_op(bit req, bit we, logic [1:0] a, logic [N-1:0] wd,
                         logic [N-1:0] ev, string tag);
        logic [N-1:0] er;
        @(negedge clk);
        bus_req_i = req; bus_we_i = we; bus_addr_i = a; bus_wdata_i = wd; evt_i = ev;
        @(posedge clk);
        er = exp_read(a);
        if (req && we) begin
            case (a)
                2'd0: m_flag = m_flag & ~wd;
                2'd1: m_en   = wd;
                2'd2: m_sel  = wd;
                default: m_le = wd[1:0];
            endcase
        end
        m_flag = m_flag | ev;
        #1;
        bus_req_i = 1'b0; evt_i = '0;
        @(negedge clk);
        chk({tag, " R5/R6 irq"}, {30'b0, irq_o}, {30'b0, exp_irq(m_flag, m_en, m_sel, m_le)});
        if (req && !we) begin
            chk({tag, " R8 rvalid"}, {31'b0, bus_rvalid_o}, 32'd1);
            chk({tag, " R7 rdata"}, bus_rdata_o, er);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq", {30'b0, irq_o}, '0);
        chk("R1 ready", {31'b0, bus_ready_o}, 32'd1);
        chk("R1 rvalid", {31'b0, bus_rvalid_o}, '0);
        for (int a = 0; a < 4; a++) do_op(1, 0, a[1:0], '0, '0, "R1 read");

        // R2 sticky set with everything masked
        do_op(0, 0, 2'd0, '0, 32'h0000_0209, "R2 set");
        do_op(1, 0, 2'd0, '0, '0, "R2 sticky");
        chk("R2 lines masked", {30'b0, irq_o}, '0);

        // R3 write-one-clear, zeros untouched
        do_op(1, 1, 2'd0, 32'h0000_0001, '0, "R3 clr");
        do_op(1, 0, 2'd0, '0, '0, "R3 readback");
        chk("R3 flags", bus_rdata_o, 32'h0000_0208);

        // R4 collision: event wins over clear
        do_op(1, 1, 2'd0, 32'h0000_0200, 32'h0000_0200, "R4 collide");
        do_op(1, 0, 2'd0, '0, '0, "R4 readback");
        chk("R4 bit9 kept", bus_rdata_o & 32'h200, 32'h200);

        // R5/R6 routing and line gating
        do_op(1, 1, 2'd1, 32'h0000_0208, '0, "R5 en");
        do_op(1, 1, 2'd3, 32'h0000_0001, '0, "R6 le0");
        chk("R6 line0 only", {30'b0, irq_o}, 32'd1);
        do_op(1, 1, 2'd2, 32'h0000_0208, '0, "R5 sel hi");
        chk("R5 moved to line1 masked", {30'b0, irq_o}, 32'd0);
        do_op(1, 1, 2'd3, 32'h0000_0003, '0, "R6 both");
        chk("R6 line1", {30'b0, irq_o}, 32'd2);
        do_op(1, 1, 2'd2, 32'h0000_0008, '0, "R5 split");
        chk("R5 both lines", {30'b0, irq_o}, 32'd3);
        do_op(1, 1, 2'd3, 32'hFFFF_FFFC, '0, "R6 mask both");
        chk("R6 none", {30'b0, irq_o}, 32'd0);
        do_op(1, 0, 2'd3, '0, '0, "R7 le zero-ext");

        // R8 request held into the response state is ignored
        @(negedge clk);
        bus_req_i = 1; bus_we_i = 1; bus_addr_i = 2'd1; bus_wdata_i = 32'hAAAA_5555;
        @(posedge clk); m_en = 32'hAAAA_5555;
        @(negedge clk);
        chk("R8 busy", {31'b0, bus_ready_o}, '0);
        bus_wdata_i = 32'h1234_5678;
        @(posedge clk); #1 bus_req_i = 0;
        do_op(1, 0, 2'd1, '0, '0, "R8 ignored");
        chk("R8 en unchanged", bus_rdata_o, 32'hAAAA_5555);
        chk("R8 rvalid single", {31'b0, bus_rvalid_o}, 32'd1);
        @(negedge clk);
        chk("R8 rvalid dropped", {31'b0, bus_rvalid_o}, '0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [N-1:0] ev;
            logic [1:0] a;
            logic [N-1:0] wd;
            bit rq, w;
            ev = $urandom & $urandom & $urandom;
            rq = ($urandom % 4) != 0;
            w  = $urandom % 2;
            a  = 2'($urandom % 4);
            wd = (a == 2'd3) ? 32'($urandom % 4) : $urandom;
            do_op(rq, w, a, wd, ev, "rand R2/R3/R5");
        end

        summary();
    end
endmodule